// File: doc/BRIEF.md
# Filter Coefficient Bank and Configuration Port

This block is the write-only control side of a dual-cell FIR engine. A processor writes over a 10-bit data bus and a 9-bit address bus. Each write is captured on the rising edge of a strobe that has no timing relation to the filter clock. Two addresses hold the control words. The block decodes their bits into named configuration outputs. Another address region holds 32 selectable coefficient sets of eight coefficients each. The first four coefficients of a set feed filter cell A and the last four feed cell B. A registered set-select input picks which set both cells see on the filter clock.

A control-word write is carried into the filter clock domain as a toggle. It starts a datapath reset that lasts a fixed number of filter clocks. This reset never clears the coefficient storage. A control word may be rewritten while the reset is still running, and the reset then restarts its count.

Top module: `cfg_coef_bank`

## Requirements
- R1: After `rst_ni` is released, every stored control bit and every coefficient reads as zero. As a result, `rev_en_o` and `rnd_en_o` are 1, all other configuration outputs are 0, both coefficient buses are 0, and `dp_rst_o` is 0.
- R2: A write to address 0x000 sets the control-word-0 outputs from the write data as follows: `dec_code_o` = data[3:0], `single_mode_o` = data[4], `odd_sym_o` = data[5], `even_taps_a_o` = data[6], `even_taps_b_o` = data[7] and `b_src_o` = data[8]. Data bit 9 is not used.
- R3: A write to address 0x001 sets the control-word-1 outputs from the write data as follows: `fmt_o` = data[3:0], `rev_en_o` = NOT data[4], `rnd_pos_o` = data[8:5] and `rnd_en_o` = NOT data[9]. In `fmt_o`, bit 0 is the cell A data format, bit 1 the cell A coefficient format, bit 2 the cell B data format and bit 3 the cell B coefficient format. For each format bit, 1 means two's complement.
- R4: A write to an address with bit 8 set stores the data as one coefficient. Address bits 7:3 give the set and bits 2:0 give the index. One filter clock after `set_sel_i` is sampled, `coef_a_o[t*10 +: 10]` shows index t of the selected set and `coef_b_o[t*10 +: 10]` shows index t+4, for t = 0 to 3.
- R5: Each write to address 0x000 or 0x001 raises `dp_rst_o` within 4 filter clocks. It then holds `dp_rst_o` high for exactly 6 consecutive filter clocks.
- R6: A control-word write made while `dp_rst_o` is high restarts the count. `dp_rst_o` then stays high without a gap for at least 6 more clocks and forms a single pulse.
- R7: Coefficient writes never assert `dp_rst_o`, and control-word writes leave every stored coefficient unchanged.
- R8: Writes to addresses 0x002 to 0x0FF change no configuration output and no coefficient, and they do not assert `dp_rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Filter clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_i | input | 1 | Write strobe; data captured on its rising edge |
| addr_i | input | 9 | Write address |
| data_i | input | 10 | Write data |
| set_sel_i | input | 5 | Coefficient set select, registered on clk_i |
| dec_code_o | output | 4 | Decimation code |
| single_mode_o | output | 1 | 1 = cells cascaded as one filter |
| odd_sym_o | output | 1 | 1 = odd-symmetric coefficients |
| even_taps_a_o | output | 1 | 1 = cell A has an even tap count |
| even_taps_b_o | output | 1 | 1 = cell B has an even tap count |
| b_src_o | output | 1 | 1 = cell B fed from the second input |
| fmt_o | output | 4 | Data and coefficient formats, 1 = two's complement |
| rev_en_o | output | 1 | Data reversal enabled |
| rnd_pos_o | output | 4 | Rounding position |
| rnd_en_o | output | 1 | Rounding enabled |
| coef_a_o | output | 40 | Four cell A coefficients of the selected set |
| coef_b_o | output | 40 | Four cell B coefficients of the selected set |
| dp_rst_o | output | 1 | Datapath reset pulse |

## Verification
The bench uses the default parameters: 32 sets, four taps per cell, 10-bit words and a 6-clock reset. With these values every one of the 256 coefficient locations can be written with random data and then read back through each select value. Because the pulse is only 6 clocks long, the exact pulse width can be measured with a short sampling window. A second control write can be placed inside a running pulse to exercise the restart.

// File: rtl/cfg_pkg.sv
`timescale 1ns/1ps
package cfg_pkg;
  // control word 0, bit 9 is not kept
  typedef struct packed {
    logic       b_src;
    logic       even_b;
    logic       even_a;
    logic       odd_sym;
    logic       single;
    logic [3:0] dec;
  } cw0_t;

  // control word 1, enables stored as written (active low)
  typedef struct packed {
    logic       rnd_dis;
    logic [3:0] rnd_pos;
    logic       rev_dis;
    logic [3:0] fmt;
  } cw1_t;
endpackage

// File: rtl/cfg_regs.sv
`timescale 1ns/1ps
module cfg_regs
  import cfg_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 10
) (
  input  logic          wr_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output cw0_t          cw0_o,
  output cw1_t          cw1_o,
  output logic          ctl_tgl_o
);
  logic hit0, hit1;
  assign hit0 = (addr_i == AW'(0));
  assign hit1 = (addr_i == AW'(1));

  always_ff @(posedge wr_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cw0_o     <= '0;
      cw1_o     <= '0;
      ctl_tgl_o <= 1'b0;
    end else begin
      if (hit0) cw0_o <= cw0_t'(data_i[8:0]);
      if (hit1) cw1_o <= cw1_t'(data_i[9:0]);
      if (hit0 || hit1) ctl_tgl_o <= ~ctl_tgl_o;
    end
  end
endmodule

// File: rtl/coef_store.sv
`timescale 1ns/1ps
module coef_store #(
  parameter int AW    = 9,
  parameter int DW    = 10,
  parameter int NSETS = 32,
  parameter int NTAPS = 4
) (
  input  logic               wr_i,
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      data_i,
  input  logic [$clog2(NSETS)-1:0] set_sel_i,
  output logic [NTAPS*DW-1:0] coef_a_o,
  output logic [NTAPS*DW-1:0] coef_b_o
);
  localparam int SETW = $clog2(NSETS);
  localparam int NIDX = 2 * NTAPS;
  localparam int IDXW = $clog2(NIDX);

  logic [DW-1:0]   mem [NSETS][NIDX];
  logic [SETW-1:0] sel_q;
  logic [SETW-1:0] wset;
  logic [IDXW-1:0] widx;

  assign widx = addr_i[IDXW-1:0];
  assign wset = addr_i[IDXW +: SETW];

  always_ff @(posedge wr_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NSETS; s++)
        for (int i = 0; i < NIDX; i++)
          mem[s][i] <= '0;
    end else if (addr_i[AW-1]) begin
      mem[wset][widx] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= set_sel_i;
  end

  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    assign coef_a_o[t*DW +: DW] = mem[sel_q][t];
    assign coef_b_o[t*DW +: DW] = mem[sel_q][NTAPS+t];
  end
endmodule

// File: rtl/rst_gen.sv
`timescale 1ns/1ps
module rst_gen #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYC     = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic dp_rst_o
);
  localparam int CW = $clog2(RST_CYC + 1);

  logic [SYNC_STAGES:0] sync_q;
  logic [CW-1:0]        cnt_q;
  logic                 evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], tgl_i};
  end

  assign evt = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (evt)           cnt_q <= CW'(RST_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign dp_rst_o = (cnt_q != '0);
endmodule

// File: rtl/cfg_coef_bank.sv
`timescale 1ns/1ps
module cfg_coef_bank
  import cfg_pkg::*;
#(
  parameter int AW          = 9,
  parameter int DW          = 10,
  parameter int NSETS       = 32,
  parameter int NTAPS       = 4,
  parameter int RST_CYC     = 6,
  parameter int SYNC_STAGES = 2,
  localparam int SETW       = $clog2(NSETS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      data_i,
  input  logic [SETW-1:0]    set_sel_i,
  output logic [3:0]         dec_code_o,
  output logic               single_mode_o,
  output logic               odd_sym_o,
  output logic               even_taps_a_o,
  output logic               even_taps_b_o,
  output logic               b_src_o,
  output logic [3:0]         fmt_o,
  output logic               rev_en_o,
  output logic [3:0]         rnd_pos_o,
  output logic               rnd_en_o,
  output logic [NTAPS*DW-1:0] coef_a_o,
  output logic [NTAPS*DW-1:0] coef_b_o,
  output logic               dp_rst_o
);
  cw0_t cw0;
  cw1_t cw1;
  logic ctl_tgl;

  cfg_regs #(.AW(AW), .DW(DW)) u_regs (
    .wr_i, .rst_ni, .addr_i, .data_i,
    .cw0_o(cw0), .cw1_o(cw1), .ctl_tgl_o(ctl_tgl)
  );

  coef_store #(.AW(AW), .DW(DW), .NSETS(NSETS), .NTAPS(NTAPS)) u_store (
    .wr_i, .clk_i, .rst_ni, .addr_i, .data_i, .set_sel_i,
    .coef_a_o, .coef_b_o
  );

  rst_gen #(.SYNC_STAGES(SYNC_STAGES), .RST_CYC(RST_CYC)) u_rst (
    .clk_i, .rst_ni, .tgl_i(ctl_tgl), .dp_rst_o
  );

  assign dec_code_o    = cw0.dec;
  assign single_mode_o = cw0.single;
  assign odd_sym_o     = cw0.odd_sym;
  assign even_taps_a_o = cw0.even_a;
  assign even_taps_b_o = cw0.even_b;
  assign b_src_o       = cw0.b_src;
  assign fmt_o         = cw1.fmt;
  assign rev_en_o      = ~cw1.rev_dis;
  assign rnd_pos_o     = cw1.rnd_pos;
  assign rnd_en_o      = ~cw1.rnd_dis;
endmodule

// File: rtl/cfg_coef_bank_chk.sv
`timescale 1ns/1ps
module cfg_coef_bank_chk #(
  parameter int AW      = 9,
  parameter int DW      = 10,
  parameter int RST_CYC = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] data_i,
  input logic [3:0]    dec_code_o,
  input logic          single_mode_o,
  input logic          odd_sym_o,
  input logic          even_taps_a_o,
  input logic          even_taps_b_o,
  input logic          b_src_o,
  input logic [3:0]    fmt_o,
  input logic          rev_en_o,
  input logic [3:0]    rnd_pos_o,
  input logic          rnd_en_o,
  input logic          dp_rst_o
);
  logic [8:0]  w0;
  logic [9:0]  w1;
  logic [7:0]  hi_cnt;
  assign w0 = {b_src_o, even_taps_b_o, even_taps_a_o, odd_sym_o, single_mode_o, dec_code_o};
  assign w1 = {~rnd_en_o, rnd_pos_o, ~rev_en_o, fmt_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      hi_cnt <= '0;
    else if (!dp_rst_o)               hi_cnt <= '0;
    else if (hi_cnt != 8'hff)         hi_cnt <= hi_cnt + 1'b1;
  end

  // R2
  cw0_load_chk: assert property (@(posedge wr_i) disable iff (!rst_ni)
    (addr_i == AW'(0)) |=> (w0 == $past(data_i[8:0])));

  // R3
  cw1_load_chk: assert property (@(posedge wr_i) disable iff (!rst_ni)
    (addr_i == AW'(1)) |=> (w1 == $past(data_i)));

  // R8
  rsvd_ignore_chk: assert property (@(posedge wr_i) disable iff (!rst_ni)
    (!addr_i[AW-1] && addr_i > AW'(1)) |=> ($stable(w0) && $stable(w1)));

  // R5
  rst_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dp_rst_o) |-> (hi_cnt >= 8'(RST_CYC)));
endmodule

bind cfg_coef_bank cfg_coef_bank_chk #(.AW(AW), .DW(DW), .RST_CYC(RST_CYC)) u_chk (
  .clk_i, .rst_ni, .wr_i, .addr_i, .data_i,
  .dec_code_o, .single_mode_o, .odd_sym_o, .even_taps_a_o, .even_taps_b_o,
  .b_src_o, .fmt_o, .rev_en_o, .rnd_pos_o, .rnd_en_o, .dp_rst_o
);

// File: tb/sim_cfg_coef_bank.sv
`timescale 1ns/1ps
module sim_cfg_coef_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [8:0]  addr_i = '0;
  logic [9:0]  data_i = '0;
  logic [4:0]  set_sel_i = '0;
  logic [3:0]  dec_code_o, fmt_o, rnd_pos_o;
  logic        single_mode_o, odd_sym_o, even_taps_a_o, even_taps_b_o, b_src_o;
  logic        rev_en_o, rnd_en_o, dp_rst_o;
  logic [39:0] coef_a_o, coef_b_o;

  int checks = 0;
  int errors = 0;
  logic [8:0] m0 = '0;
  logic [9:0] m1 = '0;
  logic [9:0] mref [32][8];

  cfg_coef_bank u0 (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [18:0] exp_cfg();
    return {m0, ~m1[9], m1[8:5], ~m1[4], m1[3:0]};
  endfunction

  function automatic logic [18:0] act_cfg();
    return {b_src_o, even_taps_b_o, even_taps_a_o, odd_sym_o, single_mode_o, dec_code_o,
            rnd_en_o, rnd_pos_o, rev_en_o, fmt_o};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // caller is at a negedge; strobe completes before the next posedge
  task automatic wr(input logic [8:0] a, input logic [9:0] d);
    addr_i = a; data_i = d;
    #2 wr_i = 1'b1;
    #6 wr_i = 1'b0;
    if (a == 9'h000) m0 = d[8:0];
    if (a == 9'h001) m1 = d;
    if (a[8]) mref[a[7:3]][a[2:0]] = d;
  endtask

  task automatic measure(input int n, input int retrig, output int hi, output int rises, output int first);
    logic prev = 1'b0;
    hi = 0; rises = 0; first = -1;
    for (int c = 0; c < n; c++) begin
      if (c == retrig) wr(9'h000, {1'b0, m0});
      @(negedge clk_i);
      if (dp_rst_o) begin
        hi++;
        if (!prev) rises++;
        if (first < 0) first = c;
      end
      prev = dp_rst_o;
    end
  endtask

  task automatic chk_set(input int s, input string req);
    logic [39:0] ea, eb;
    set_sel_i = 5'(s);
    @(negedge clk_i);
    for (int t = 0; t < 4; t++) begin
      ea[t*10 +: 10] = mref[s][t];
      eb[t*10 +: 10] = mref[s][4+t];
    end
    chk(coef_a_o == ea && coef_b_o == eb, req, {coef_a_o, coef_b_o}, {ea, eb});
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi, rises, first;
    logic [18:0] snap;
    void'($urandom(32'd1234));
    for (int s = 0; s < 32; s++) for (int i = 0; i < 8; i++) mref[s][i] = '0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk(act_cfg() == 19'h00210 && dp_rst_o == 1'b0, "R1", 80'(act_cfg()), 80'h00210);
    chk_set(0, "R1");
    chk_set(31, "R1");

    // R2 / R3 directed and random control words
    wr(9'h000, 10'h3ff); @(negedge clk_i);
    chk(act_cfg() == exp_cfg(), "R2", 80'(act_cfg()), 80'(exp_cfg()));
    wr(9'h001, 10'h210); @(negedge clk_i);
    chk(act_cfg() == exp_cfg(), "R3", 80'(act_cfg()), 80'(exp_cfg()));
    for (int k = 0; k < 6; k++) begin
      wr(9'h000, 10'($urandom)); repeat (10) @(negedge clk_i);
      chk(act_cfg() == exp_cfg(), "R2", 80'(act_cfg()), 80'(exp_cfg()));
      wr(9'h001, 10'($urandom)); repeat (10) @(negedge clk_i);
      chk(act_cfg() == exp_cfg(), "R3", 80'(act_cfg()), 80'(exp_cfg()));
    end
    repeat (10) @(negedge clk_i);

    // R4 / R7: fill the whole bank, no reset pulse from coefficient writes
    rises = 0;
    for (int s = 0; s < 32; s++)
      for (int i = 0; i < 8; i++) begin
        wr({1'b1, 5'(s), 3'(i)}, 10'($urandom));
        @(negedge clk_i);
        if (dp_rst_o) rises++;
      end
    wr({1'b1, 5'd9, 3'd7}, 10'h3ff); @(negedge clk_i);
    wr({1'b1, 5'd9, 3'd0}, 10'h000); @(negedge clk_i);
    repeat (6) begin @(negedge clk_i); if (dp_rst_o) rises++; end
    chk(rises == 0, "R7", 80'(rises), 80'd0);
    for (int s = 0; s < 32; s++) chk_set(s, "R4");
    chk_set(9, "R4");

    // R5 single pulse width and latency
    wr(9'h001, {1'b0, m1[8:0]});
    measure(20, -1, hi, rises, first);
    chk(hi == 6 && rises == 1, "R5", 80'({hi[15:0], rises[15:0]}), 80'({16'd6, 16'd1}));
    chk(first <= 4, "R5", 80'(first), 80'd4);

    // R6 retrigger during pulse
    wr(9'h000, {1'b0, m0});
    measure(24, 4, hi, rises, first);
    chk(rises == 1 && hi >= 8, "R6", 80'({hi[15:0], rises[15:0]}), 80'({16'd8, 16'd1}));

    // R7 control writes left coefficients intact
    for (int s = 0; s < 32; s += 5) chk_set(s, "R7");

    // R8 reserved and unused low addresses
    snap = act_cfg();
    rises = 0;
    for (int a = 2; a <= 'h11; a++) begin
      wr(9'(a), 10'($urandom)); @(negedge clk_i);
      if (dp_rst_o) rises++;
    end
    for (int k = 0; k < 8; k++) begin
      wr(9'(8'h12 + 8'($urandom_range(0, 'hed))), 10'($urandom)); @(negedge clk_i);
      if (dp_rst_o) rises++;
    end
    wr(9'h0ff, 10'h3ff);
    repeat (6) begin @(negedge clk_i); if (dp_rst_o) rises++; end
    chk(rises == 0, "R8", 80'(rises), 80'd0);
    chk(act_cfg() == snap, "R8", 80'(act_cfg()), 80'(snap));
    chk_set(0, "R8");
    chk_set(31, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule